// File: doc/BRIEF.md
# Dual-Slot Frame Receive Buffer

This block takes in Ethernet frames as a byte stream and keeps each finished frame in one of two on-chip receive slots. Each slot holds up to 2048 bytes. Software reaches the slots through a small 32-bit register port that is addressed by word. Each slot has a state register and a byte-count register. Software hands a slot to the receiver by writing the LOADED code into its state. The receiver fills the slot with the next frame, records the byte count and marks the slot PENDING. Software then reads the frame through a separate memory read port and hands the slot back.

The stream carries every byte of the frame on the wire: seven 0x55 preamble bytes, the 0xD5 start delimiter, the payload and the four CRC bytes. The stored length is therefore the payload length plus 12. The receiver picks the slot when a frame starts. It always prefers slot 0. If neither slot is LOADED, the frame is dropped without any trace. A frame becomes visible to software only once its last byte has been accepted.

A level interrupt shows that at least one frame is waiting. A ready output shows that a slot is free to receive.

Top module: `rx_slot_buffer`

## Requirements
- R1: After reset, every register reads zero, `rx_irq` is low and `rx_ready` is low.
- R2: Register word addresses are: 2 for slot-0 state, 3 for slot-0 count, 4 for slot-1 state and 5 for slot-1 count. State codes are EMPTY=0, LOADED=1 and PENDING=2, held in bits [1:0]. Count registers can be written and read back. Words 0, 1 and 6 read as zero, and writes to them have no effect.
- R3: `rx_ready` is high exactly when at least one slot state is LOADED.
- R4: The slot is chosen at the first byte of a frame. Slot 0 is used if it is LOADED; otherwise slot 1 is used if it is LOADED.
- R5: A frame that starts while neither slot is LOADED is dropped. No state or count register changes, and `rx_irq` is unchanged.
- R6: Byte k of a stored frame is read at slot offset k. Read data appears on `mem_rd_data` one clock after the slot and offset are presented. The stored count includes the preamble, delimiter and CRC bytes.
- R7: A slot's count and state change only when the last byte is accepted. Until then the slot stays LOADED and keeps its old count.
- R8: A frame longer than 2048 bytes is discarded. Its slot stays LOADED with its old count. A frame of exactly 2048 bytes is stored with count 2048.
- R9: `rx_irq` is high exactly when either slot is PENDING. It follows a completed frame and any software write to a state register from the next clock onward.
- R10: A one-byte frame, with valid and last in the same cycle, is stored with count 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte of a frame |
| mem_rd_slot | input | 1 | Slot selected for memory read |
| mem_rd_addr | input | 11 | Byte offset for memory read |
| mem_rd_data | output | 8 | Memory read data, one clock latency |
| rx_irq | output | 1 | Level interrupt: a slot is PENDING |
| rx_ready | output | 1 | A slot is LOADED and can receive |

## Verification
The properties assume that software does not write a slot's state or count in the same cycle that a frame commits into that slot. They also assume that software does not change slot states while a frame is being received. The directed tests keep register writes and stream bytes in separate phases, so both assumptions always hold. The properties also assume that a frame's last byte is always marked, so that frames never run together. Every generated frame ends with `in_last`.

// File: rtl/rx_slot_buffer.sv
module rx_slot_buffer #(
  parameter int SLOT_BYTES = 2048,
  parameter int REG_AW     = 3,
  parameter int PTR_W      = $clog2(SLOT_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic              mem_rd_slot,
  input  logic [PTR_W-1:0]  mem_rd_addr,
  output logic [7:0]        mem_rd_data,
  output logic              rx_irq,
  output logic              rx_ready
);
  localparam int CNT_W = PTR_W + 1;
  localparam logic [1:0] ST_LOADED  = 2'd1;
  localparam logic [1:0] ST_PENDING = 2'd2;

  logic [1:0]       state_q [2];
  logic [CNT_W-1:0] count_q [2];
  logic [7:0]       rd_q    [2];
  logic             in_frame_q, sel_q, drop_q, rd_slot_q;
  logic [CNT_W-1:0] ptr_q;

  logic             loaded0, loaded1, sel_now, drop_now, fits, wr_en, commit;
  logic [CNT_W-1:0] ptr_now;
  logic [1:0]       st0, st1;
  logic [CNT_W-1:0] cnt0, cnt1;

  assign loaded0  = state_q[0] == ST_LOADED;
  assign loaded1  = state_q[1] == ST_LOADED;
  assign rx_ready = loaded0 | loaded1;
  assign rx_irq   = (state_q[0] == ST_PENDING) | (state_q[1] == ST_PENDING);

  assign sel_now  = in_frame_q ? sel_q  : !loaded0;
  assign drop_now = in_frame_q ? drop_q : !rx_ready;
  assign ptr_now  = in_frame_q ? ptr_q  : '0;
  assign fits     = ptr_now < CNT_W'(SLOT_BYTES);
  assign wr_en    = in_valid && !drop_now && fits;
  assign commit   = wr_en && in_last;

  assign st0  = state_q[0];
  assign st1  = state_q[1];
  assign cnt0 = count_q[0];
  assign cnt1 = count_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      sel_q      <= 1'b0;
      drop_q     <= 1'b0;
      ptr_q      <= '0;
    end else if (in_valid) begin
      if (in_last) begin
        in_frame_q <= 1'b0;
        drop_q     <= 1'b0;
        ptr_q      <= '0;
      end else begin
        in_frame_q <= 1'b1;
        sel_q      <= sel_now;
        drop_q     <= drop_now | !fits;
        ptr_q      <= wr_en ? ptr_now + 1'b1 : ptr_now;
      end
    end
  end

  for (genvar s = 0; s < 2; s++) begin : g_slot
    localparam logic [REG_AW-1:0] A_STATE = REG_AW'(2 + 2 * s);
    localparam logic [REG_AW-1:0] A_COUNT = REG_AW'(3 + 2 * s);
    logic [7:0] mem [SLOT_BYTES];
    logic       hit;
    assign hit = sel_now == 1'(s);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        state_q[s] <= '0;
        count_q[s] <= '0;
      end else if (commit && hit) begin
        state_q[s] <= ST_PENDING;
        count_q[s] <= ptr_now + 1'b1;
      end else if (reg_we) begin
        if (reg_addr == A_STATE) state_q[s] <= reg_wdata[1:0];
        if (reg_addr == A_COUNT) count_q[s] <= reg_wdata[CNT_W-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && hit) mem[ptr_now[PTR_W-1:0]] <= in_data;
      rd_q[s] <= mem[mem_rd_addr];
    end
  end

  always_ff @(posedge clk) rd_slot_q <= mem_rd_slot;
  assign mem_rd_data = rd_q[rd_slot_q];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_AW'(2): reg_rdata[1:0]       = state_q[0];
      REG_AW'(3): reg_rdata[CNT_W-1:0] = count_q[0];
      REG_AW'(4): reg_rdata[1:0]       = state_q[1];
      REG_AW'(5): reg_rdata[CNT_W-1:0] = count_q[1];
      default:    reg_rdata            = '0;
    endcase
  end
endmodule

// File: rtl/rx_slot_buffer_props.sv
module rx_slot_buffer_props #(
  parameter int SLOT_BYTES = 2048,
  parameter int REG_AW     = 3,
  parameter int CNT_W      = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              in_valid,
  input logic              in_frame_q,
  input logic              rx_irq,
  input logic              rx_ready,
  input logic              commit,
  input logic              sel_now,
  input logic [1:0]        st0,
  input logic [1:0]        st1,
  input logic [CNT_W-1:0]  cnt0,
  input logic [CNT_W-1:0]  cnt1
);
  assert_irq_after_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> rx_irq);

  assert_count0_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !sel_now) |=> (cnt0 != '0 && cnt0 <= CNT_W'(SLOT_BYTES)));

  assert_count1_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && sel_now) |=> (cnt1 != '0 && cnt1 <= CNT_W'(SLOT_BYTES)));

  assert_ready_after_handback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == REG_AW'(2) && reg_wdata[1:0] == 2'd1 && !(commit && !sel_now))
    |=> rx_ready);

  assert_irq_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == REG_AW'(2) && reg_wdata[1:0] != 2'd2 && st1 != 2'd2 && !commit)
    |=> !rx_irq);

  assert_drop_keeps_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_frame_q && !rx_ready && !reg_we) |=> ($stable(st0) && $stable(st1)));

  assert_idle_keeps_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !reg_we) |=> ($stable(st0) && $stable(st1)));
endmodule

bind rx_slot_buffer rx_slot_buffer_props #(
  .SLOT_BYTES(SLOT_BYTES), .REG_AW(REG_AW), .CNT_W(CNT_W)
) i_props (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .in_valid(in_valid), .in_frame_q(in_frame_q),
  .rx_irq(rx_irq), .rx_ready(rx_ready), .commit(commit), .sel_now(sel_now),
  .st0(st0), .st1(st1), .cnt0(cnt0), .cnt1(cnt1)
);

// File: tb/test_rx_slot_buffer.sv
module test_rx_slot_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int NBYTES = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        mem_rd_slot = 1'b0;
  logic [10:0] mem_rd_addr = '0;
  logic [7:0]  mem_rd_data;
  logic        rx_irq, rx_ready;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_slot_buffer i_rx_slot_buffer (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
    .in_data(in_data), .in_last(in_last), .mem_rd_slot(mem_rd_slot),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .rx_irq(rx_irq), .rx_ready(rx_ready)
  );

  function automatic logic [7:0] byte_of(int seed, int i);
    if (i < 7) return 8'h55;
    if (i == 7) return 8'hD5;
    return 8'(seed + i * 29);
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cpu_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic cpu_read(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic mem_read(logic s, int a, output logic [7:0] d);
    @(negedge clk);
    mem_rd_slot = s; mem_rd_addr = 11'(a);
    @(negedge clk);
    d = mem_rd_data;
  endtask

  task automatic send(int n, int seed, int start, bit with_last);
    for (int i = start; i < start + n; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = byte_of(seed, i);
      in_last = with_last && (i == start + n - 1);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic expect_reg(string req, logic [2:0] a, logic [31:0] exp);
    logic [31:0] v;
    cpu_read(a, v);
    check(req, $sformatf("reg[%0d]", a), v, exp);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 7; a++) expect_reg("R1", 3'(a), 32'd0);
    check("R1", "rx_irq", rx_irq, 1'b0);
    check("R1", "rx_ready", rx_ready, 1'b0);
  endtask

  task automatic t_regmap();
    cpu_write(3'd0, 32'h3); cpu_write(3'd1, 32'h5); cpu_write(3'd6, 32'h77);
    expect_reg("R2", 3'd0, 0); expect_reg("R2", 3'd1, 0); expect_reg("R2", 3'd6, 0);
    cpu_write(3'd3, 32'h123); cpu_write(3'd5, 32'h456);
    expect_reg("R2", 3'd3, 32'h123); expect_reg("R2", 3'd5, 32'h456);
    cpu_write(3'd3, 0); cpu_write(3'd5, 0);
  endtask

  task automatic t_drop_empty();
    send(16, 3, 0, 1'b1);
    expect_reg("R5", 3'd2, 0); expect_reg("R5", 3'd3, 0);
    expect_reg("R5", 3'd4, 0); expect_reg("R5", 3'd5, 0);
    check("R5", "rx_irq", rx_irq, 1'b0);
  endtask

  task automatic t_first_frame();
    logic [7:0] b;
    cpu_write(3'd2, 1); cpu_write(3'd4, 1);
    check("R3", "rx_ready both loaded", rx_ready, 1'b1);
    send(20, 11, 0, 1'b1);
    expect_reg("R4", 3'd2, 2); expect_reg("R6", 3'd3, 20);
    expect_reg("R4", 3'd4, 1);
    check("R9", "rx_irq after frame", rx_irq, 1'b1);
    mem_read(1'b0, 0, b);  check("R6", "slot0[0]", b, 8'h55);
    mem_read(1'b0, 7, b);  check("R6", "slot0[7]", b, 8'hD5);
    mem_read(1'b0, 12, b); check("R6", "slot0[12]", b, byte_of(11, 12));
    mem_read(1'b0, 19, b); check("R6", "slot0[19]", b, byte_of(11, 19));
  endtask

  task automatic t_second_frame();
    logic [7:0] b;
    send(64, 40, 0, 1'b1);
    expect_reg("R4", 3'd4, 2); expect_reg("R6", 3'd5, 64);
    expect_reg("R4", 3'd3, 20);
    check("R3", "rx_ready none loaded", rx_ready, 1'b0);
    mem_read(1'b1, 63, b); check("R6", "slot1[63]", b, byte_of(40, 63));
    send(30, 5, 0, 1'b1);
    expect_reg("R5", 3'd3, 20); expect_reg("R5", 3'd5, 64);
    expect_reg("R5", 3'd2, 2);  expect_reg("R5", 3'd4, 2);
    mem_read(1'b0, 12, b); check("R5", "slot0 untouched", b, byte_of(11, 12));
  endtask

  task automatic t_irq_handback();
    cpu_write(3'd2, 1);
    check("R9", "irq with slot1 pending", rx_irq, 1'b1);
    check("R3", "ready after slot0 handback", rx_ready, 1'b1);
    cpu_write(3'd4, 1);
    check("R9", "irq none pending", rx_irq, 1'b0);
  endtask

  task automatic t_partial();
    send(10, 9, 0, 1'b0);
    expect_reg("R7", 3'd2, 1); expect_reg("R7", 3'd3, 20);
    check("R7", "irq mid-frame", rx_irq, 1'b0);
    send(1, 9, 10, 1'b1);
    expect_reg("R7", 3'd2, 2); expect_reg("R7", 3'd3, 11);
    expect_reg("R7", 3'd4, 1);
    cpu_write(3'd2, 1);
  endtask

  task automatic t_overflow();
    logic [7:0] b;
    send(NBYTES + 1, 77, 0, 1'b1);
    expect_reg("R8", 3'd2, 1); expect_reg("R8", 3'd3, 11);
    check("R8", "irq after overflow", rx_irq, 1'b0);
    send(NBYTES, 88, 0, 1'b1);
    expect_reg("R8", 3'd2, 2); expect_reg("R8", 3'd3, NBYTES);
    mem_read(1'b0, NBYTES - 1, b); check("R8", "slot0[last]", b, byte_of(88, NBYTES - 1));
    mem_read(1'b0, 100, b); check("R8", "slot0[100]", b, byte_of(88, 100));
  endtask

  task automatic t_single_byte();
    logic [7:0] b;
    send(1, 1, 0, 1'b1);
    expect_reg("R10", 3'd4, 2); expect_reg("R10", 3'd5, 1);
    mem_read(1'b1, 0, b); check("R10", "slot1[0]", b, 8'h55);
    check("R3", "ready both pending", rx_ready, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_drop_empty();
    t_first_frame();
    t_second_frame();
    t_irq_handback();
    t_partial();
    t_overflow();
    t_single_byte();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule